// File: doc/BRIEF.md
# Descriptor-Chained Audio Playback DMA

This block is a bus-master engine for audio playback. It walks a chain of region descriptors held in memory. Each descriptor is two 32-bit words. The first word gives the start address of a region of 16-bit samples. The second word carries a byte count and three control flags. The engine reads the region one 32-bit word at a time and splits each word into two samples. It sends each sample out on a stream that is tagged with one of two codec slot numbers.

Software controls the engine through three registers: a command register, a read-to-clear status register and a descriptor pointer. The engine advances the pointer itself, one descriptor at a time. The descriptor flags let software do three things. It can mark the end of the chain. It can request a page notification. It can jump to another part of the table, so that circular buffers are possible. If a second page notification arrives before software has acknowledged the first, the engine freezes until software reads the status register.

Top module: `audio_prd_dma`

## Requirements
- R1: After reset, all three registers read 0, and `mem_req` and `smp_valid` are low.
- R2: The command register (reg_addr 0) stores the enable flag in bit 0 and the direction flag in bit 3. All other bits read back as 0. The direction flag has no effect on the engine: with enable at 0, no memory request is made.
- R3: The pointer register (reg_addr 2) stores a write with bits 1:0 forced to 0. Each descriptor that is not a jump advances it by 8, so a read returns the address of the next descriptor.
- R4: A descriptor is fetched as word 0 at the pointer, then word 1 at the pointer plus 4. In word 1, bit 31 marks end of chain, bit 30 requests a page notification, bit 29 marks a jump, and bits 15:0 hold the region byte count.
- R5: Memory words are read in order from the region start, one word per request. Each word gives its low half and then its high half as samples on consecutive cycles, while at least 4 bytes remain. A remainder of 1 to 3 bytes gives one sample, the low half. A count of 0 gives no samples.
- R6: `smp_slot` is 6 when `slot_sel` is 0 and 11 when `slot_sel` is 1.
- R7: Finishing a region whose page flag is set sets status bit 0 (reg_addr 1).
- R8: If a page notification completes while status bit 0 is still set, status bit 1 is set. From then on, no memory request is made until the status register is read.
- R9: A status read (reg_rd with reg_addr 1) returns the current bits and clears both of them, which releases a pause.
- R10: When an end-of-chain region finishes, the engine clears the enable bit and makes no further requests.
- R11: For a jump descriptor, word 0 with bits 1:0 cleared becomes the new pointer. No samples come from that descriptor.
- R12: If enable is cleared during a transfer, the engine completes the memory read already requested, including both samples of its word. It then goes idle and makes no more requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status on reg_addr 1) |
| reg_addr | input | 2 | 0 command, 1 status, 2 pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| slot_sel | input | 1 | Slot tag select |
| mem_req | output | 1 | Read request, held until `mem_rvalid` |
| mem_addr | output | 32 | Word-aligned read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| smp_valid | output | 1 | Sample valid pulse |
| smp_data | output | 16 | Sample value |
| smp_slot | output | 4 | Slot tag |

## Verification
The assertions assume three things about the memory side. It returns exactly one `mem_rvalid` for each request. It never returns data while `mem_req` is low. It never answers a request in the same cycle that the request first appears. The bench memory model meets all three by latching a request, answering two cycles later and then ignoring `mem_req` for one cycle. The bench also clears enable only in the ways the requirements allow: while a region is transferring, or after the end of the chain.

// File: rtl/audio_prd_dma.sv
module audio_prd_dma #(
  parameter int SLOT_LO = 6,
  parameter int SLOT_HI = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        slot_sel,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        smp_valid,
  output logic [15:0] smp_data,
  output logic [3:0]  smp_slot
);
  localparam logic [1:0] A_CMD = 2'd0, A_STAT = 2'd1, A_PTR = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_D0, S_D1, S_DATA, S_HI, S_DONE} state_t;
  state_t state;

  logic        cmd_en, cmd_dir, stat_eop, stat_err, f_eot, f_eop;
  logic [29:0] ptr_q, cur_q;
  logic [15:0] remain, hold;

  wire clr     = reg_rd && reg_addr == A_STAT;
  wire eop_evt = state == S_DONE && f_eop;
  wire req_st  = state == S_D0 || state == S_D1 || state == S_DATA;

  assign mem_req  = req_st && !stat_err;
  assign mem_addr = state == S_D0 ? {ptr_q, 2'b00} :
                    state == S_D1 ? {ptr_q + 30'd1, 2'b00} : {cur_q, 2'b00};
  assign smp_slot = slot_sel ? 4'(SLOT_HI) : 4'(SLOT_LO);

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = {28'd0, cmd_dir, 2'b00, cmd_en};
      A_STAT:  reg_rdata = {30'd0, stat_err, stat_eop};
      A_PTR:   reg_rdata = {ptr_q, 2'b00};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cmd_en <= 1'b0; cmd_dir <= 1'b0;
      stat_eop <= 1'b0; stat_err <= 1'b0;
      f_eot <= 1'b0; f_eop <= 1'b0;
      ptr_q <= '0; cur_q <= '0; remain <= '0; hold <= '0;
      smp_valid <= 1'b0; smp_data <= '0;
    end else begin
      smp_valid <= 1'b0;
      if (reg_wr && reg_addr == A_CMD) begin
        cmd_en  <= reg_wdata[0];
        cmd_dir <= reg_wdata[3];
      end
      if (reg_wr && reg_addr == A_PTR) ptr_q <= reg_wdata[31:2];
      stat_eop <= (stat_eop && !clr) || eop_evt;
      stat_err <= (stat_err && !clr) || (eop_evt && stat_eop && !clr);

      if (req_st && stat_err && !cmd_en) state <= S_IDLE;
      else case (state)
        S_IDLE: if (cmd_en) state <= S_D0;
        S_D0: if (mem_rvalid) begin
          cur_q <= mem_rdata[31:2];
          state <= S_D1;
        end
        S_D1: if (mem_rvalid) begin
          if (mem_rdata[29]) begin
            ptr_q <= cur_q;
            state <= cmd_en ? S_D0 : S_IDLE;
          end else begin
            ptr_q  <= ptr_q + 30'd2;
            remain <= mem_rdata[15:0];
            f_eot  <= mem_rdata[31];
            f_eop  <= mem_rdata[30];
            state  <= !cmd_en ? S_IDLE : (mem_rdata[15:0] == 16'd0 ? S_DONE : S_DATA);
          end
        end
        S_DATA: if (mem_rvalid) begin
          smp_valid <= 1'b1;
          smp_data  <= mem_rdata[15:0];
          hold      <= mem_rdata[31:16];
          cur_q     <= cur_q + 30'd1;
          if (remain >= 16'd4) begin
            remain <= remain - 16'd4;
            state  <= S_HI;
          end else begin
            remain <= 16'd0;
            state  <= cmd_en ? S_DONE : S_IDLE;
          end
        end
        S_HI: begin
          smp_valid <= 1'b1;
          smp_data  <= hold;
          state <= !cmd_en ? S_IDLE : (remain == 16'd0 ? S_DONE : S_DATA);
        end
        S_DONE: begin
          if (f_eot) begin
            cmd_en <= 1'b0;
            state  <= S_IDLE;
          end else state <= cmd_en ? S_D0 : S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_pause_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_err |-> !mem_req);
  p_err_after_eop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_err) |-> $past(stat_eop));
  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && state != S_DONE) |=> (!stat_eop && !stat_err));
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_D1 && mem_rvalid && !mem_rdata[29] && !(reg_wr && reg_addr == A_PTR))
      |=> ptr_q == $past(ptr_q) + 30'd2);
  p_eot_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DONE && f_eot) |=> (!cmd_en && !mem_req));
  p_hi_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_HI |=> smp_valid);
endmodule

// File: tb/tb_audio_prd_dma.sv
module tb_audio_prd_dma;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, slot_sel = 0, mem_rvalid = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, mem_addr, mem_rdata = 0;
  logic mem_req, smp_valid;
  logic [15:0] smp_data;
  logic [3:0] smp_slot;

  always #10 clk = ~clk;

  audio_prd_dma dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slot_sel(slot_sel),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_slot(smp_slot));

  logic [31:0] mem [0:255];
  logic pend = 0;
  logic [7:0] pidx = 0;
  always @(posedge clk) begin
    if (mem_rvalid) mem_rvalid <= 0;
    else if (pend) begin mem_rvalid <= 1; mem_rdata <= mem[pidx]; pend <= 0; end
    else if (mem_req) begin pend <= 1; pidx <= mem_addr[9:2]; end
  end

  int ns = 0, reqcnt = 0, checks = 0, errors = 0;
  logic [15:0] sbuf [0:63];
  logic [3:0] slbuf [0:63];
  always @(negedge clk) begin
    if (smp_valid) begin
      if (ns < 64) begin sbuf[ns] = smp_data; slbuf[ns] = smp_slot; end
      ns++;
    end
    if (mem_req) reqcnt++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic rdclr(output logic [31:0] v);
    @(negedge clk); reg_addr = 2'd1; reg_rd = 1; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      peek(2'd0, v);
      if (v[0] == 1'b0) break;
    end
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [31:0] fill(input int i);
    return {16'(i * 37 + 11), 16'(i * 91 + 3)};
  endfunction

  function automatic logic [15:0] exp_smp(input int base, input int k);
    logic [31:0] w;
    w = fill(base / 4 + k / 2);
    return (k % 2) ? w[31:16] : w[15:0];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int tot;
    for (int i = 0; i < 256; i++) mem[i] = fill(i);
    repeat (3) @(negedge clk);
    rst_n = 1;

    peek(2'd0, v); chk("R1 cmd", v, 0);
    peek(2'd1, v); chk("R1 status", v, 0);
    peek(2'd2, v); chk("R1 ptr", v, 0);
    chk("R1 mem_req", {31'd0, mem_req}, 0);
    chk("R1 smp_valid", {31'd0, smp_valid}, 0);

    wr(2'd0, 32'hFE); peek(2'd0, v); chk("R2 cmd readback", v, 32'h08);
    reqcnt = 0; repeat (20) @(negedge clk);
    chk("R2 direction no effect", reqcnt, 0);
    wr(2'd0, 0);
    wr(2'd2, 32'h103); peek(2'd2, v); chk("R3 ptr low bits", v, 32'h100);

    for (int n = 0; n <= 14; n++) begin
      mem[64] = 32'h200; mem[65] = 32'h8000_0000 | n;
      slot_sel = n[0];
      ns = 0;
      wr(2'd2, 32'h100); wr(2'd0, 1);
      wait_idle();
      tot = 2 * (n / 4) + ((n % 4) != 0 ? 1 : 0);
      chk("R5 sample count", ns, tot);
      for (int k = 0; k < tot; k++) begin
        chk("R5 sample data", {16'd0, sbuf[k]}, {16'd0, exp_smp(32'h200, k)});
        chk("R6 slot tag", {28'd0, slbuf[k]}, n[0] ? 11 : 6);
      end
      peek(2'd2, v); chk("R3 ptr advance", v, 32'h108);
      peek(2'd0, v); chk("R10 enable cleared", v, 0);
      peek(2'd1, v); chk("R7 no page flag", v, 0);
      reqcnt = 0; repeat (10) @(negedge clk);
      chk("R10 no further requests", reqcnt, 0);
    end

    mem[64] = 32'h200; mem[65] = 32'h4000_0004;
    mem[66] = 32'h240; mem[67] = 32'h4000_0004;
    mem[68] = 32'h280; mem[69] = 32'hC000_0004;
    ns = 0; slot_sel = 0;
    wr(2'd2, 32'h100); wr(2'd0, 1);
    for (int i = 0; i < 500; i++) begin
      peek(2'd1, v);
      if (v[1]) break;
    end
    chk("R8 error bit", v, 3);
    reqcnt = 0; repeat (20) @(negedge clk);
    chk("R8 paused no requests", reqcnt, 0);
    peek(2'd2, v); chk("R3 ptr at pause", v, 32'h110);
    chk("R4 samples before pause", ns, 4);
    rdclr(v); chk("R9 read returns bits", v, 3);
    wait_idle();
    chk("R9 resumed samples", ns, 6);
    chk("R4 third region data", {16'd0, sbuf[4]}, {16'd0, exp_smp(32'h280, 0)});
    peek(2'd1, v); chk("R7 page flag set", v, 1);
    rdclr(v); chk("R9 read value", v, 1);
    peek(2'd1, v); chk("R9 cleared", v, 0);

    mem[64] = 32'h183; mem[65] = 32'h2000_0008;
    mem[96] = 32'h300; mem[97] = 32'h8000_0004;
    ns = 0;
    wr(2'd2, 32'h100); wr(2'd0, 1);
    wait_idle();
    chk("R11 jump sample count", ns, 2);
    chk("R11 jump data lo", {16'd0, sbuf[0]}, {16'd0, exp_smp(32'h300, 0)});
    chk("R11 jump data hi", {16'd0, sbuf[1]}, {16'd0, exp_smp(32'h300, 1)});
    peek(2'd2, v); chk("R11 ptr after jump", v, 32'h188);

    mem[64] = 32'h200; mem[65] = 32'h8000_0040;
    ns = 0;
    wr(2'd2, 32'h100); wr(2'd0, 1);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (ns >= 1) break;
    end
    wr(2'd0, 0);
    repeat (10) @(negedge clk);
    reqcnt = 0; repeat (20) @(negedge clk);
    chk("R12 no requests after disable", reqcnt, 0);
    chk("R12 whole beat delivered", ns % 2, 0);
    chk("R12 stopped early", {31'd0, ns < 32}, 1);
    chk("R12 at least one beat", {31'd0, ns >= 2}, 1);
    peek(2'd0, v); chk("R12 enable off", v, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule